// File: doc/BRIEF.md
# Programmable Input Deglitch Filter Bank

The block conditions a bank of digital input pins before software or downstream logic reads them. Every pin is first brought into the system clock domain by a two-stage synchroniser. Each channel can then either pass its synchronised level straight on, or pass it through a glitch filter that accepts a new level only after the pin has held that level across consecutive samples taken one programmed interval apart. A level that lasts less than one interval is never passed.

All channels share one interval generator. The interval is counted in units of a fixed slow time base: the system clock is divided by `PRE_DIV`, which gives 200 ns units at 250 MHz with the default. Software writes an enable mask and a staged interval through a byte-wide write port. A separate strobe register makes a staged interval take effect, and it can also reset every channel's filter state, so outputs line up with the current pins at once. Filtered levels come out on `pins_out`, with channel n on bit n.

Top module: `deglitch_bank`

## Requirements
- R1: After reset every output bit is 0, the enable mask is 0 so no channel filters, and the active interval is 0.
- R2: An unfiltered channel shows a pin change on its output exactly three clock edges after the change: two synchroniser stages and one output register.
- R3: A filtered channel changes its output only on an interval tick at which the synchronised input equals the sample taken at the previous tick. A level shorter than one interval never reaches the output, and a level held for two intervals always does.
- R4: The enable mask is written at addresses 0, 1 and 2, which hold channels 7..0, 15..8 and 23..16. Channel n sits at bit n%8 of its byte, and a 1 enables filtering. A mask write takes effect at once, with no strobe.
- R5: The staged interval is 20 bits, written at address 4 (bits 7..0), 5 (bits 15..8) and 6 (bits 19..16 in data bits 3..0). Data bits 7..4 written to address 6 are ignored. One interval unit is `PRE_DIV` clock cycles.
- R6: Writing to address 7 with data bit 0 set copies the staged interval into the active interval and restarts the tick phase. Writing the staged interval bytes alone leaves the filter timing unchanged.
- R7: Writing to address 7 with data bit 1 set loads every channel's stored sample and output with its current synchronised input, on the same clock edge.
- R8: An active interval of 0 behaves as an interval of 1 unit, so ticks never stop.
- R9: Interval ticks fall only on unit boundaries, one every max(interval,1) units. No tick occurs in the cycle after a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pins_in | input | NCH | Asynchronous input pins |
| pins_out | output | NCH | Synchronised and optionally filtered levels |

## Verification
On every cycle the assertions check the following:
- Interval ticks land only on unit boundaries, the interval counter stays below its effective limit, and no tick follows a commit directly.
- The active interval moves only on a commit.
- A filtered output stays still between ticks, and it also stays still at a tick where the two samples differ.
- A clear strobe makes each output equal to its synchroniser value.

Some behaviour only the bench scenarios can show. These are the exact three-edge latency of unfiltered channels, and the way the mask bytes map onto channels. They also include the fact that staged bytes do nothing until committed, that the high nibble of the top interval byte is dropped, and that a zero interval acts as one unit. Finally they show how pulses shorter or longer than the interval are rejected or passed.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  localparam int          BYTE_W     = 8;
  localparam logic [2:0]  A_EN_BASE  = 3'd0;
  localparam logic [2:0]  A_IV_BASE  = 3'd4;
  localparam logic [2:0]  A_STROBE   = 3'd7;
  localparam int          STB_COMMIT = 0;
  localparam int          STB_FLTCLR = 1;

  // A programmed interval of zero counts as one unit.
  function automatic logic [31:0] eff_interval(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

  // Next output of one channel.
  function automatic logic filt_next(input logic en, input logic tick,
                                     input logic clr, input logic cur,
                                     input logic held, input logic prev);
    if (clr || !en)            return cur;
    if (tick && (cur == held)) return cur;
    return prev;
  endfunction

endpackage

// File: rtl/deglitch_regs.sv
module deglitch_regs
  import deglitch_pkg::*;
#(
  parameter int NCH   = 24,
  parameter int IVL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [NCH-1:0]   en_mask,
  output logic [IVL_W-1:0] act_interval,
  output logic             commit,
  output logic             flt_clr
);

  localparam int NBYTES   = (NCH + BYTE_W - 1) / BYTE_W;
  localparam int IV_BYTES = (IVL_W + BYTE_W - 1) / BYTE_W;

  logic [NCH-1:0]   en_q;
  logic [IVL_W-1:0] stage_q;
  logic [IVL_W-1:0] act_q;
  logic [NCH-1:0]   en_next;
  logic [IVL_W-1:0] stage_next;
  logic             strobe_wr;

  assign strobe_wr = wr_en && (wr_addr == A_STROBE);
  assign commit    = strobe_wr && wr_data[STB_COMMIT];
  assign flt_clr   = strobe_wr && wr_data[STB_FLTCLR];

  // Byte merges: the masks drop bits above the field width (top nibble of the interval).
  always_comb begin
    en_next    = en_q;
    stage_next = stage_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en && (wr_addr == A_EN_BASE + 3'(b))) begin
        en_next = (en_next & ~NCH'(32'hFF << (b * BYTE_W)))
                | (NCH'(32'(wr_data) << (b * BYTE_W)));
      end
    end
    for (int b = 0; b < IV_BYTES; b++) begin
      if (wr_en && (wr_addr == A_IV_BASE + 3'(b))) begin
        stage_next = (stage_next & ~IVL_W'(32'hFF << (b * BYTE_W)))
                   | (IVL_W'(32'(wr_data) << (b * BYTE_W)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      en_q    <= en_next;
      stage_q <= stage_next;
      if (commit) act_q <= stage_q;
    end
  end

  assign en_mask      = en_q;
  assign act_interval = act_q;

  // R6: the active interval moves only on a commit strobe
  p_active_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));

endmodule

// File: rtl/deglitch_tick.sv
module deglitch_tick
  import deglitch_pkg::*;
#(
  parameter int PRE_DIV = 50,
  parameter int IVL_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IVL_W-1:0] act_interval,
  output logic             unit_tick,
  output logic             ivl_tick
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [IVL_W-1:0] cnt_q;
  logic [31:0]      eff32;
  logic [31:0]      last32;
  logic [IVL_W-1:0] cnt_last;

  assign eff32     = eff_interval(32'(act_interval));
  assign last32    = eff32 - 32'd1;
  assign cnt_last  = last32[IVL_W-1:0];
  assign unit_tick = (pre_q == PRE_LAST);
  assign ivl_tick  = unit_tick && (cnt_q == cnt_last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= unit_tick ? '0 : pre_q + 1'b1;
      if (unit_tick) cnt_q <= ivl_tick ? '0 : cnt_q + 1'b1;
    end
  end

  // R9: interval ticks fall only on unit boundaries
  p_tick_on_unit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_tick |-> unit_tick);

  // R8: counter stays below the effective interval, so a zero interval still ticks
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < eff32);

  // R9: a commit restarts the phase, so no tick in the following cycle
  p_no_tick_after_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ivl_tick);

endmodule

// File: rtl/deglitch_chan.sv
module deglitch_chan
  import deglitch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic q
);

  logic sync1_q, sync2_q, held_q, out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      held_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      if (clr || !en || tick) held_q <= sync2_q;
      out_q <= filt_next(en, tick, clr, sync2_q, held_q, out_q);
    end
  end

  assign q = out_q;

  // R3: a filtered output is still between ticks
  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !clr) |=> $stable(out_q));

  // R3: a tick with disagreeing samples leaves the output alone
  p_need_agreement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !clr && (sync2_q != held_q)) |=> $stable(out_q));

  // R7: the clear strobe aligns the output with the synchroniser
  p_clear_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_q == $past(sync2_q)));

endmodule

// File: rtl/deglitch_bank.sv
module deglitch_bank
  import deglitch_pkg::*;
#(
  parameter int NCH     = 24,
  parameter int IVL_W   = 20,
  parameter int PRE_DIV = 50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [NCH-1:0] pins_in,
  output logic [NCH-1:0] pins_out
);

  logic [NCH-1:0]   en_mask;
  logic [IVL_W-1:0] act_interval;
  logic             commit;
  logic             flt_clr;
  logic             unit_tick;
  logic             ivl_tick;

  deglitch_regs #(.NCH(NCH), .IVL_W(IVL_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .en_mask      (en_mask),
    .act_interval (act_interval),
    .commit       (commit),
    .flt_clr      (flt_clr)
  );

  deglitch_tick #(.PRE_DIV(PRE_DIV), .IVL_W(IVL_W)) u_tick (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (commit),
    .act_interval (act_interval),
    .unit_tick    (unit_tick),
    .ivl_tick     (ivl_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    deglitch_chan u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pins_in[c]),
      .en    (en_mask[c]),
      .tick  (ivl_tick),
      .clr   (flt_clr),
      .q     (pins_out[c])
    );
  end

  // R3: every filtered output bit is frozen between interval ticks
  p_bank_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ivl_tick && !flt_clr) |=> (($past(pins_out) ^ pins_out) & $past(en_mask)) == '0);

endmodule

// File: tb/deglitch_bank_test.sv
`timescale 1ns/1ps
module deglitch_bank_test;

  localparam int NCH = 24;
  localparam int DIV = 50;

  typedef struct packed {
    logic [23:0] en;
    logic [23:0] base;
    logic [23:0] pulse;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'h000000, 24'h000000, 24'hFFFFFF},
    '{24'hFFFFFF, 24'h000000, 24'hFFFFFF},
    '{24'h0000FF, 24'h00F0F0, 24'h0F0F0F},
    '{24'hFF0000, 24'hA5A5A5, 24'h5A5A5A},
    '{24'h00FF00, 24'h123456, 24'hEDCBA9},
    '{24'h800001, 24'h000000, 24'h800001}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] pins_in = '0;
  logic [NCH-1:0] pins_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  deglitch_bank #(.NCH(NCH), .IVL_W(20), .PRE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pins_in(pins_in), .pins_out(pins_out)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_pins(input logic [23:0] v);
    @(negedge clk);
    pins_in = v;
  endtask

  task automatic set_mask(input logic [23:0] m);
    wr(3'd0, m[7:0]);
    wr(3'd1, m[15:8]);
    wr(3'd2, m[23:16]);
  endtask

  initial begin
    cyc(5);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1);
    check("R1 reset outputs", pins_out, 24'h0);

    // R2 and R1: no filtering after reset, three-edge latency
    @(negedge clk);
    pins_in = 24'hFFFFFF;
    @(posedge clk); @(posedge clk); #1;
    check("R2 not yet after two edges", pins_out, 24'h0);
    @(posedge clk); #1;
    check("R2 R1 visible after three edges", pins_out, 24'hFFFFFF);
    set_pins(24'h0);
    cyc(5);

    // R8: zero interval acts as one unit; R4 channel 0 at bit 0 of address 0
    wr(3'd0, 8'h01);
    set_pins(24'h000001);
    cyc(115);
    check("R8 R4 pulse passes with zero interval", pins_out, 24'h000001);
    set_pins(24'h0);
    cyc(250);

    // R6: staged bytes alone change nothing
    wr(3'd4, 8'h03); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    set_pins(24'h000001);
    cyc(115);
    check("R6 staged interval not yet active", pins_out, 24'h000001);
    set_pins(24'h0);
    cyc(250);
    wr(3'd7, 8'h01);
    set_pins(24'h000001);
    cyc(115);
    check("R6 committed interval blocks short pulse", pins_out, 24'h0);
    set_pins(24'h0);
    cyc(10);
    check("R6 still blocked after pulse", pins_out, 24'h0);
    cyc(320);

    // R5: upper nibble of address 6 dropped, interval becomes 2 units
    wr(3'd4, 8'h02); wr(3'd6, 8'hF0); wr(3'd7, 8'h01);
    set_pins(24'h000001);
    cyc(228);
    check("R5 R9 long pulse passes with interval 2", pins_out, 24'h000001);
    set_pins(24'h0);
    cyc(300);
    check("R5 returns low", pins_out, 24'h0);
    set_pins(24'h000001);
    cyc(88);
    check("R5 pulse under one interval blocked", pins_out, 24'h0);
    set_pins(24'h0);
    cyc(10);
    check("R5 blocked after release", pins_out, 24'h0);
    cyc(220);

    // R3: interval 3 units, bounds of acceptance
    wr(3'd4, 8'h03); wr(3'd7, 8'h01);
    set_pins(24'h000001);
    cyc(148);
    check("R3 not passed before one interval", pins_out, 24'h0);
    cyc(162);
    check("R3 R9 passed after two intervals", pins_out, 24'h000001);
    set_pins(24'h0);
    cyc(320);

    // R4 R3 table: mask layout, pass-through and glitch rejection
    for (int i = 0; i < 6; i++) begin
      set_mask(VECS[i].en);
      set_pins(VECS[i].base);
      cyc(320);
      check($sformatf("R4 vec%0d settled", i), pins_out, VECS[i].base);
      set_pins(VECS[i].pulse);
      cyc(98);
      check($sformatf("R3 R4 vec%0d during glitch", i), pins_out,
            (VECS[i].pulse & ~VECS[i].en) | (VECS[i].base & VECS[i].en));
      set_pins(VECS[i].base);
      cyc(5);
      check($sformatf("R3 vec%0d after glitch", i), pins_out, VECS[i].base);
      cyc(320);
    end

    // R7: clear strobe loads current inputs (mask 800001 in force)
    set_pins(24'h000001);
    cyc(3);
    check("R7 filtered before clear", pins_out, 24'h0);
    wr(3'd7, 8'h02);
    check("R7 output follows input after clear", pins_out, 24'h000001);
    cyc(5);
    check("R7 held after clear", pins_out, 24'h000001);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule